// File: doc/BRIEF.md
# Prescaled PWM Timer with Shadowed Compare

This block is a 16-bit counter with a programmable clock divider and a single compare channel that drives one PWM pin. The counter can run in edge-aligned fashion, counting up or down, or in one of three center-aligned fashions that sweep up to the period limit and back down. The compare channel turns the count into a waveform. It can produce a normal or an inverted PWM output, or hold the pin at a fixed level. A one-shot option stops the counter after a single period. Used with the inverted PWM output, this gives a programmable delay followed by a pulse.

Software programs the block through a simple synchronous write port. The divider, period and compare values are each written to a preload register. Each is copied into an active (shadow) register on an update event, or at once when software issues an update request. For the period and compare values, a preload-enable bit can bypass the shadow so that a new value takes effect immediately. Two sticky flags report update events and compare matches, and software clears each flag by writing 0 to it.

Top module: `pwm_timer`

## Requirements
- R1: The counter advances once every P+1 clock cycles, where P is the active divider value. It holds its value while the run bit is 0. The divider is the register at address 2.
- R2: With alignment 00 in control bits [3:2], the counter behaves as follows. With direction bit 1 = 0 it counts 0,1,..,A and then 0, where A is the active period (the register at address 3). With direction bit 1 = 1 it counts A,..,0 and then A. Each wrap is an update event.
- R3: With alignments 01, 10 and 11, the counter counts up from 0 to A and back down, for a period of 2×A ticks. Update events occur on leaving A and on leaving 0 while counting down.
- R4: After reset, the active divider is 0 and the active period is 0xFFFF. With preload enabled, writes to the preload registers do not affect counting until an update.
- R5: Writing 1 to bit 0 of address 6 (the software update request) does all of the following in the same edge. It copies every preload value into its shadow and sets the update flag. It restarts the divider count. It sets the counter to A for an edge-aligned down count, and to 0 otherwise.
- R6: Control bit 5 enables period preload and control bit 6 enables compare preload. When a bit is 1, a new value waits for the next update event. When it is 0, the new value acts from the next tick. The compare register is at address 4.
- R7: A compare match occurs on a tick while the count equals the compare value C. The match sets the compare flag in edge-aligned mode and in alignment 11. Alignment 01 sets the flag only while counting down, and alignment 10 only while counting up.
- R8: The output mode is in channel bits [3:0] (address 1). Mode 0110 makes the output active while count < C. Mode 0111 is the inverse. In edge-aligned mode 0110, C=0 gives 0% duty and C ≥ A+1 gives 100% duty.
- R9: Mode 0100 holds the output inactive and mode 0101 holds it active.
- R10: Channel bit 4 = 1 inverts the output, where 0 means active-high. Channel bit 5 = 0 holds the pin at 0.
- R11: With control bit 4 set, the run bit (control bit 0) clears at the next update event. With mode 0111, the output then gives C inactive ticks and A+1−C active ticks.
- R12: The update flag and the compare flag stay set until cleared. Software clears them by writing address 5 with bit 0 (update) or bit 1 (compare) at 0. A bit written as 1 leaves its flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 channel, 2 divider, 3 period, 4 compare, 5 flags, 6 event) |
| wr_data | input | 16 | Write data |
| pwm_o | output | 1 | PWM pin |
| upd_flag_o | output | 1 | Sticky update flag |
| cmp_flag_o | output | 1 | Sticky compare flag |
| count_o | output | 16 | Current counter value |
| running_o | output | 1 | Run bit (clears itself in one-shot mode) |

## Verification
Several properties are checked on every cycle. The counter must stay still between divider ticks. Each edge-aligned up tick must step by one or wrap to zero, and each in-range center-aligned tick must step by one in either direction. A software update must leave the flag set and the count at its start value. The flags must stay set unless software clears them, and a one-shot update must drop the run bit. Other behaviours show up only in the bench's scenarios: the exact tick counts, and which direction qualifies a compare match in each center mode. The same holds for the duty extremes at C=0 and C=A+1, the deferred effect of preloaded values, the reset-time shadow values and the delay-then-pulse shape.

// File: rtl/timer_pkg.sv
// Shared definitions for the prescaled PWM timer.
// Assumes a 3-bit register address space; all encodings are fixed here.
package timer_pkg;

    typedef enum logic [1:0] {
        ALIGN_EDGE   = 2'b00,
        ALIGN_C_DOWN = 2'b01,
        ALIGN_C_UP   = 2'b10,
        ALIGN_C_BOTH = 2'b11
    } align_e;

    localparam logic [2:0] ADR_CTRL  = 3'd0;
    localparam logic [2:0] ADR_CHAN  = 3'd1;
    localparam logic [2:0] ADR_DIV   = 3'd2;
    localparam logic [2:0] ADR_PER   = 3'd3;
    localparam logic [2:0] ADR_CMP   = 3'd4;
    localparam logic [2:0] ADR_FLAGS = 3'd5;
    localparam logic [2:0] ADR_EVENT = 3'd6;

    localparam logic [3:0] OM_FORCE_LO = 4'b0100;
    localparam logic [3:0] OM_FORCE_HI = 4'b0101;
    localparam logic [3:0] OM_PWM_A    = 4'b0110;
    localparam logic [3:0] OM_PWM_B    = 4'b0111;

endpackage

// File: rtl/tmr_divider.sv
// Clock divider: emits one tick every LIMIT+1 cycles while run is high.
// Assumes restart has priority and zeroes the internal phase count.
module tmr_divider #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] phase;

    // Tick when the phase count has reached the limit (>= covers a lowered limit).
    assign tick = run && (phase >= limit);

    // Phase counter: restart on request, otherwise wrap at each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase <= '0;
        end else if (run) begin
            phase <= tick ? '0 : phase + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_counter.sv
// Main counter: edge-aligned up/down or center-aligned sweep.
// Assumes tick comes from the divider and restart wins over tick.
module tmr_counter
    import timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         restart,
    input  align_e       align,
    input  logic         dir_dn,
    input  logic [W-1:0] limit,
    input  logic [W-1:0] start_dn,
    output logic [W-1:0] cnt,
    output logic         going_dn,
    output logic         upd_evt
);
    logic [W-1:0] cnt_nxt;
    logic         dn_state, dn_nxt, wrap;

    // Effective direction: control bit in edge mode, sweep state in center modes.
    assign going_dn = (align == ALIGN_EDGE) ? dir_dn : dn_state;
    assign upd_evt  = tick && wrap;

    // Next-count and wrap computation for the selected alignment.
    always_comb begin
        cnt_nxt = cnt;
        dn_nxt  = dn_state;
        wrap    = 1'b0;
        if (align == ALIGN_EDGE) begin
            if (!dir_dn) begin
                if (cnt >= limit) begin cnt_nxt = '0; wrap = 1'b1; end
                else              cnt_nxt = cnt + 1'b1;
            end else begin
                if (cnt == '0 || cnt > limit) begin cnt_nxt = limit; wrap = 1'b1; end
                else                          cnt_nxt = cnt - 1'b1;
            end
        end else if (limit == '0) begin
            cnt_nxt = '0;
            wrap    = 1'b1;
        end else if (!dn_state) begin
            if (cnt >= limit) begin
                cnt_nxt = limit - 1'b1;
                dn_nxt  = 1'b1;
                wrap    = 1'b1;
            end else begin
                cnt_nxt = cnt + 1'b1;
            end
        end else begin
            if (cnt == '0) begin
                cnt_nxt = {{(W-1){1'b0}}, 1'b1};
                dn_nxt  = 1'b0;
                wrap    = 1'b1;
            end else begin
                cnt_nxt = cnt - 1'b1;
            end
        end
    end

    // Count register and center sweep direction state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            dn_state <= 1'b0;
        end else if (restart) begin
            cnt      <= (align == ALIGN_EDGE && dir_dn) ? start_dn : '0;
            dn_state <= 1'b0;
        end else if (tick) begin
            cnt      <= cnt_nxt;
            dn_state <= dn_nxt;
        end
    end
endmodule

// File: rtl/tmr_channel.sv
// Compare channel: builds the output level and the direction-qualified match.
// Assumes cnt and compare are already the effective (shadowed or direct) values.
module tmr_channel
    import timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] compare,
    input  logic [3:0]   mode,
    input  logic         invert,
    input  logic         out_en,
    input  align_e       align,
    input  logic         going_dn,
    input  logic         tick,
    output logic         pin,
    output logic         match
);
    logic below, active, dir_ok;

    assign below = cnt < compare;

    // Reference level from the output mode.
    always_comb begin
        case (mode)
            OM_PWM_A:    active = below;
            OM_PWM_B:    active = !below;
            OM_FORCE_HI: active = 1'b1;
            default:     active = 1'b0;
        endcase
    end

    // Direction qualifier for the compare flag per alignment.
    always_comb begin
        case (align)
            ALIGN_C_DOWN: dir_ok = going_dn;
            ALIGN_C_UP:   dir_ok = !going_dn;
            default:      dir_ok = 1'b1;
        endcase
    end

    assign pin   = out_en && (active ^ invert);
    assign match = tick && (cnt == compare) && dir_ok;
endmodule

// File: rtl/pwm_timer.sv
// Top: register file, preload/shadow registers, flags and sub-block wiring.
// Assumes one write per cycle; the event register is write-only (a pulse).
module pwm_timer
    import timer_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              pwm_o,
    output logic              upd_flag_o,
    output logic              cmp_flag_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              running_o
);
    localparam logic [CNT_W-1:0] PER_RST = '1;

    logic             run, dir_dn, one_shot, per_pre_en, cmp_pre_en;
    align_e           align;
    logic [3:0]       mode;
    logic             invert, out_en;
    logic [CNT_W-1:0] div_pre, per_pre, cmp_pre;
    logic [CNT_W-1:0] div_sh, per_sh, cmp_sh;
    logic [CNT_W-1:0] per_eff, cmp_eff;
    logic             sw_upd, tick, upd_evt, going_dn, match;

    function automatic logic hit(input logic [2:0] a);
        return wr_en && (3'(wr_addr) == a);
    endfunction

    assign sw_upd  = hit(ADR_EVENT) && wr_data[0];
    assign per_eff = per_pre_en ? per_sh : per_pre;
    assign cmp_eff = cmp_pre_en ? cmp_sh : cmp_pre;

    // Control and channel fields; one-shot clears run at an update event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0; dir_dn <= 1'b0; align <= ALIGN_EDGE;
            one_shot <= 1'b0; per_pre_en <= 1'b0; cmp_pre_en <= 1'b0;
            mode <= 4'b0000; invert <= 1'b0; out_en <= 1'b0;
        end else begin
            if (hit(ADR_CTRL)) begin
                run        <= wr_data[0];
                dir_dn     <= wr_data[1];
                align      <= align_e'(wr_data[3:2]);
                one_shot   <= wr_data[4];
                per_pre_en <= wr_data[5];
                cmp_pre_en <= wr_data[6];
            end else if (upd_evt && one_shot) begin
                run <= 1'b0;
            end
            if (hit(ADR_CHAN)) begin
                mode   <= wr_data[3:0];
                invert <= wr_data[4];
                out_en <= wr_data[5];
            end
        end
    end

    // Preload registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_pre <= '0; per_pre <= PER_RST; cmp_pre <= '0;
        end else begin
            if (hit(ADR_DIV)) div_pre <= wr_data;
            if (hit(ADR_PER)) per_pre <= wr_data;
            if (hit(ADR_CMP)) cmp_pre <= wr_data;
        end
    end

    // Shadow transfer on an update event or a software update request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_sh <= '0; per_sh <= PER_RST; cmp_sh <= '0;
        end else if (upd_evt || sw_upd) begin
            div_sh <= div_pre; per_sh <= per_pre; cmp_sh <= cmp_pre;
        end
    end

    // Sticky flags: set wins over a software clear written as 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_flag_o <= 1'b0;
            cmp_flag_o <= 1'b0;
        end else begin
            if (upd_evt || sw_upd)                  upd_flag_o <= 1'b1;
            else if (hit(ADR_FLAGS) && !wr_data[0]) upd_flag_o <= 1'b0;
            if (match)                              cmp_flag_o <= 1'b1;
            else if (hit(ADR_FLAGS) && !wr_data[1]) cmp_flag_o <= 1'b0;
        end
    end

    tmr_divider #(.W(CNT_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(sw_upd),
        .limit(div_sh), .tick(tick)
    );

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(sw_upd),
        .align(align), .dir_dn(dir_dn), .limit(per_eff), .start_dn(per_pre),
        .cnt(count_o), .going_dn(going_dn), .upd_evt(upd_evt)
    );

    tmr_channel #(.W(CNT_W)) u_ch (
        .cnt(count_o), .compare(cmp_eff), .mode(mode), .invert(invert),
        .out_en(out_en), .align(align), .going_dn(going_dn), .tick(tick),
        .pin(pwm_o), .match(match)
    );

    assign running_o = run;
endmodule

// File: rtl/pwm_timer_chk.sv
// Checker for pwm_timer, attached by bind; observes ports and internal strobes.
module pwm_timer_chk
    import timer_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [2:0]   wr_addr,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] count_o,
    input logic         running_o,
    input logic         upd_flag_o,
    input logic         tick,
    input logic         sw_upd,
    input logic         upd_evt,
    input logic         one_shot,
    input align_e       align,
    input logic         dir_dn,
    input logic [W-1:0] per_eff,
    input logic [W-1:0] per_pre
);
    // R1
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !sw_upd) |=> $stable(count_o));

    // R2
    edge_up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !sw_upd && align == ALIGN_EDGE && !dir_dn)
        |=> (count_o == W'($past(count_o) + 1'b1)) || (count_o == '0));

    // R3
    center_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !sw_upd && align != ALIGN_EDGE && per_eff != '0 && count_o < per_eff)
        |=> (count_o == W'($past(count_o) + 1'b1)) || (count_o == W'($past(count_o) - 1'b1)));

    // R5
    ug_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_upd |=> upd_flag_o && ((count_o == '0) || (count_o == $past(per_pre))));

    // R12
    upd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_flag_o && !(wr_en && wr_addr == ADR_FLAGS && !wr_data[0])) |=> upd_flag_o);

    // R11
    opm_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && upd_evt && one_shot && !(wr_en && wr_addr == ADR_CTRL)) |=> !running_o);
endmodule

bind pwm_timer pwm_timer_chk #(.W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(3'(wr_addr)),
    .wr_data(wr_data), .count_o(count_o), .running_o(running_o),
    .upd_flag_o(upd_flag_o), .tick(tick), .sw_upd(sw_upd), .upd_evt(upd_evt),
    .one_shot(one_shot), .align(align), .dir_dn(dir_dn), .per_eff(per_eff),
    .per_pre(per_pre)
);

// File: tb/pwm_timer_tb.sv
// Bench: directed corner cases plus a sweep of divider, period, compare and
// alignment, with expected values derived arithmetically from tick counts.
module pwm_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_o, upd_flag_o, cmp_flag_o, running_o;
    logic [15:0] count_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwm_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_o(pwm_o), .upd_flag_o(upd_flag_o),
        .cmp_flag_o(cmp_flag_o), .count_o(count_o), .running_o(running_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a negedge; one register write on the following edge.
    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int pos_of(input int t, input int al, input int dn, input int arr);
        int p;
        if (al == 0) return dn ? arr - (t % (arr + 1)) : t % (arr + 1);
        p = t % (2 * arr);
        return (p <= arr) ? p : 2 * arr - p;
    endfunction

    function automatic bit dn_at(input int j, input int al, input int dn, input int arr);
        int p;
        if (al == 0) return dn[0];
        p = j % (2 * arr);
        return (p > arr) || (p == 0 && j > 0);
    endfunction

    task automatic sweep_one(input int al, input int dn, input int psc, input int arr,
                             input int ccr, input int mode, input int pol);
        int ctrl, kmax, t, j, f, pv;
        bit eu, ec, act, sd;
        ctrl = (dn << 1) | (al << 2) | 32'h60;
        wr(0, ctrl); wr(1, mode | (pol << 4) | 32'h20);
        wr(2, psc); wr(3, arr); wr(4, ccr); wr(6, 1);
        chk("R5 start count", count_o, (al == 0 && dn) ? arr : 0);
        wr(5, 0); wr(0, ctrl | 1);
        eu = 0; ec = 0;
        kmax = (psc + 1) * (4 * arr + 1);
        for (int k = 1; k <= kmax; k++) begin
            @(negedge clk);
            if (k % (psc + 1) == 0) begin
                j = k / (psc + 1) - 1;
                f = pos_of(j, al, dn, arr);
                sd = dn_at(j, al, dn, arr);
                if (al == 0) eu |= dn ? (f == 0) : (f == arr);
                else         eu |= (f == arr && !sd) || (f == 0 && sd);
                if (f == ccr && (al == 0 || al == 3 || (al == 1 && sd) || (al == 2 && !sd)))
                    ec = 1;
            end
            t = k / (psc + 1);
            pv = pos_of(t, al, dn, arr);
            chk(al == 0 ? "R1 R2 count" : "R1 R3 count", count_o, pv);
            act = (mode == 6) ? (pv < ccr) : !(pv < ccr);
            chk("R8 R10 pwm", pwm_o, act ^ pol[0]);
            chk("R7 compare flag", cmp_flag_o, ec);
            chk(al == 0 ? "R2 R12 update flag" : "R3 R12 update flag", upd_flag_o, eu);
        end
        wr(0, ctrl);
    endtask

    task automatic preload_case(input int b);
        wr(0, b ? 32'h60 : 0); wr(1, 32'h26); wr(2, 0); wr(3, 9); wr(4, 5);
        wr(6, 1); wr(5, 0); wr(0, (b ? 32'h60 : 0) | 1);
        @(negedge clk); @(negedge clk);
        wr(4, 1);
        chk("R6 compare preload pwm", pwm_o, b ? 1 : 0);
        wr(3, 3);
        chk("R6 count after period write", count_o, 4);
        @(negedge clk);
        chk("R6 period preload", count_o, b ? 5 : 0);
        if (b) begin
            repeat (5) @(negedge clk);
            chk("R6 wrap at old period", count_o, 0);
            repeat (3) @(negedge clk);
            chk("R6 new period in use", count_o, 3);
            chk("R6 new compare in use", pwm_o, 0);
            @(negedge clk);
            chk("R6 wrap at new period", count_o, 0);
        end
        wr(0, 0);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R4 reset count", count_o, 0);
        chk("R10 reset pin", pwm_o, 0);
        chk("R12 reset update flag", upd_flag_o, 0);
        chk("R12 reset compare flag", cmp_flag_o, 0);

        // R4: reset shadows are divider 0 and period 0xFFFF.
        wr(3, 5); wr(2, 3); wr(0, 32'h21);
        repeat (8) @(negedge clk);
        chk("R4 reset shadows in use", count_o, 8);
        wr(0, 32'h20);
        @(negedge clk); @(negedge clk);
        chk("R1 hold while stopped", count_o, 9);
        wr(6, 1);
        chk("R5 update request clears count", count_o, 0);
        chk("R5 update request sets flag", upd_flag_o, 1);
        wr(5, 0);
        chk("R12 update flag cleared", upd_flag_o, 0);
        wr(0, 32'h21);
        for (int k = 1; k <= 30; k++) begin
            @(negedge clk);
            chk("R1 divide by four", count_o, (k / 4) % 6);
        end
        wr(6, 1);
        repeat (3) @(negedge clk);
        chk("R5 divider restarted", count_o, 0);
        @(negedge clk);
        chk("R5 first tick after restart", count_o, 1);
        wr(0, 0);

        preload_case(0);
        preload_case(1);

        // R9 R10: forced levels, inversion and output enable.
        wr(1, 32'h24); chk("R9 force inactive", pwm_o, 0);
        wr(1, 32'h25); chk("R9 force active", pwm_o, 1);
        wr(1, 32'h35); chk("R10 inverted active", pwm_o, 0);
        wr(1, 32'h34); chk("R10 inverted inactive", pwm_o, 1);
        wr(1, 32'h15); chk("R10 output disabled", pwm_o, 0);
        wr(1, 32'h14); chk("R10 output disabled inverted", pwm_o, 0);

        // R11: one-shot, delay 3 then pulse of 5.
        wr(0, 32'h10); wr(1, 32'h27); wr(2, 0); wr(3, 7); wr(4, 3);
        wr(6, 1); wr(5, 0); wr(0, 32'h11);
        for (int k = 1; k <= 14; k++) begin
            @(negedge clk);
            chk("R11 one-shot count", count_o, (k <= 7) ? k : 0);
            chk("R11 one-shot pin", pwm_o, (k >= 3 && k <= 7) ? 1 : 0);
            chk("R11 run bit", running_o, (k <= 7) ? 1 : 0);
        end
        chk("R11 update flag", upd_flag_o, 1);

        // R12: selective clearing of flags.
        chk("R12 compare flag set", cmp_flag_o, 1);
        wr(5, 2);
        chk("R12 update cleared", upd_flag_o, 0);
        chk("R12 compare kept", cmp_flag_o, 1);
        wr(5, 0);
        chk("R12 compare cleared", cmp_flag_o, 0);

        // R1 R2 R3 R7 R8: sweep over the small configuration space.
        for (int ms = 0; ms < 5; ms++)
            for (int psc = 0; psc < 3; psc++)
                for (int arr = 1; arr < 5; arr++)
                    for (int ci = 0; ci < 4; ci++) begin
                        int ccr;
                        ccr = (ci == 0) ? 0 : (ci == 1) ? 1 : (ci == 2) ? arr : arr + 1;
                        sweep_one((ms < 2) ? 0 : ms - 1, (ms == 1) ? 1 : 0, psc, arr,
                                  ccr, (ci % 2) ? 7 : 6, (psc == 1) ? 1 : 0);
                    end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule